// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast oscillator clock by a ratio that has an integer part and a fractional part. The block counts input clock edges and emits one pulse for each division cycle. Each cycle is either N or N+1 input clocks long. A first-order accumulator adds the fraction word once per cycle. When the sum reaches the programmable modulus, the accumulator wraps and that cycle is one clock longer. Over every modulus-long run of cycles, the average ratio is therefore N + F/M.

In a synthesizer loop the divided pulse goes to the phase comparator. The output frequency is then the comparison frequency times N + F/M. With N = 900, F = 1 and M = 5 at a 1 MHz comparison rate, the output is 900.2 MHz. Reaching the same output step with integer division alone would need a comparison rate five times lower (ratio 4501 at 0.2 MHz).

The modulus may be any value up to 25 bits, including values that are not powers of two. The integer, fraction and modulus words are sampled only at a cycle boundary, so the cycle in progress is never disturbed. Illegal words are clamped to legal values, and an error flag reports this.

Top module: `frac_n_divider`

## Requirements
- R1: While rst_ni is low, pulse_o, ratio_o and cfg_err_o are all 0.
- R2: With a fraction word of 0, every division cycle lasts exactly int_i input clocks and ratio_o equals int_i. There is no dithering.
- R3: Over any M consecutive cycles that use the same legal settings, the cycle lengths add up to M*N + F. For N=900, F=1, M=5, five cycles total 4501 clocks.
- R4: A cycle lasts N+1 clocks exactly when the accumulator overflows for that cycle, and N clocks otherwise.
  - The accumulator starts at 0 after reset.
  - At each cycle start, F is added to it.
  - If the sum is at least M, M is subtracted and the cycle is long.
  - Example: N=7, F=2, M=5 gives lengths 7,7,8,7,8 repeating.
- R5: pulse_o is high for exactly one input clock, on the last clock of each cycle. ratio_o holds the length of the current cycle.
- R6: Input words are sampled only at the clock edge that ends a cycle (and at the first edge after reset). A change in the middle of a cycle does not alter that cycle's length, and it takes effect from the next cycle.
- R7: A modulus of 0 is treated as modulus 1 with fraction 0, and cfg_err_o is 1 from that boundary on.
- R8: A fraction word of M or more is clamped to M-1, and cfg_err_o is 1 from that boundary on. cfg_err_o returns to 0 at the first boundary that samples legal words.
- R9: An integer word of 0 is treated as 1, and cfg_err_o is 1 from that boundary on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| int_i | input | INT_W | Integer part N of the ratio |
| frac_i | input | MOD_W | Fraction numerator F |
| mod_i | input | MOD_W | Fraction modulus M |
| pulse_o | output | 1 | One-clock pulse on the last clock of each cycle |
| ratio_o | output | INT_W+1 | Length of the current cycle (N or N+1) |
| cfg_err_o | output | 1 | Words sampled at the last boundary were illegal and were clamped |

## Verification
The divider is driven with several kinds of settings:
- A zero fraction, which isolates plain integer counting.
- Small fractions over moduli 5 and 7, whose cycle-by-cycle length sequences show where the accumulator wraps. Because 7 is not a power of two, a carry taken from the top bit of the sum would give a different sequence.
- The 900 + 1/5 setting, which confirms the 4501-clock total over one modulus period.
- Illegal words (modulus 0, fraction at or above the modulus, integer 0), which check both the clamped lengths and the error flag.
- A change of the integer word in the middle of a cycle, which shows whether the words are sampled only at cycle boundaries.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/fd_cfg_clamp.sv
module fd_cfg_clamp #(
  parameter int INT_W = 12,
  parameter int MOD_W = 25
) (
  input  logic [INT_W-1:0] int_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic [INT_W-1:0] int_o,
  output logic [MOD_W-1:0] frac_o,
  output logic [MOD_W-1:0] mod_o,
  output logic             err_o
);
  logic mod_bad, frac_bad, int_bad;

  always_comb begin
    mod_bad  = (mod_i == '0);
    mod_o    = mod_bad ? MOD_W'(1) : mod_i;
    frac_bad = (frac_i >= mod_o);
    frac_o   = frac_bad ? (mod_o - MOD_W'(1)) : frac_i;
    int_bad  = (int_i == '0);
    int_o    = int_bad ? INT_W'(1) : int_i;
    err_o    = mod_bad | frac_bad | int_bad;
  end
endmodule

// File: rtl/fd_frac_acc.sv
module fd_frac_acc #(
  parameter int MOD_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MOD_W-1:0] frac_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             carry_o,
  output logic [MOD_W-1:0] acc_o
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] acc_q, acc_use;
  logic [SUM_W-1:0] sum, wrapped;

  always_comb begin
    // a shrunken modulus can leave a stale residue above it: restart from 0
    acc_use = (acc_q >= mod_i) ? '0 : acc_q;
    sum     = {1'b0, acc_use} + {1'b0, frac_i};
    carry_o = (sum >= {1'b0, mod_i});
    wrapped = carry_o ? (sum - {1'b0, mod_i}) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= wrapped[MOD_W-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fd_cycle_cnt.sv
module fd_cycle_cnt
  import frac_div_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] len_i,
  output logic             load_o,
  output logic             pulse_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q == '0);
  assign load_o  = (state_q == ST_IDLE) | last;
  assign pulse_o = (state_q == ST_RUN) & last;
  assign run_o   = (state_q == ST_RUN);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      cnt_q   <= len_i - CNT_W'(1);
    end else begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider #(
  parameter int INT_W = 12,
  parameter int MOD_W = 25
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INT_W-1:0]   int_i,
  input  logic [MOD_W-1:0]   frac_i,
  input  logic [MOD_W-1:0]   mod_i,
  output logic               pulse_o,
  output logic [INT_W:0]     ratio_o,
  output logic               cfg_err_o
);
  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0] int_c;
  logic [MOD_W-1:0] frac_c, mod_c, acc;
  logic             err_c, carry, load, running;
  logic [CNT_W-1:0] len, cnt;
  logic [CNT_W-1:0] ratio_q;
  logic             err_q;

  fd_cfg_clamp #(.INT_W(INT_W), .MOD_W(MOD_W)) u_clamp (
    .int_i (int_i),
    .frac_i(frac_i),
    .mod_i (mod_i),
    .int_o (int_c),
    .frac_o(frac_c),
    .mod_o (mod_c),
    .err_o (err_c)
  );

  fd_frac_acc #(.MOD_W(MOD_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .frac_i (frac_c),
    .mod_i  (mod_c),
    .carry_o(carry),
    .acc_o  (acc)
  );

  assign len = {1'b0, int_c} + CNT_W'(carry);

  fd_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .len_i  (len),
    .load_o (load),
    .pulse_o(pulse_o),
    .run_o  (running),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= '0;
      err_q   <= 1'b0;
    end else if (load) begin
      ratio_q <= len;
      err_q   <= err_c;
    end
  end

  assign ratio_o   = ratio_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/frac_n_divider_chk.sv
module frac_n_divider_chk #(
  parameter int INT_W = 12,
  parameter int MOD_W = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [INT_W-1:0] int_i,
  input logic [MOD_W-1:0] frac_i,
  input logic [MOD_W-1:0] mod_i,
  input logic             pulse_o,
  input logic [INT_W:0]   ratio_o,
  input logic             cfg_err_o,
  input logic             load,
  input logic             running,
  input logic [INT_W:0]   cnt
);
  p_pulse_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (!pulse_o || ratio_o == 1));

  p_cnt_below_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> (cnt < ratio_o));

  p_ratio_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !pulse_o) |=> $stable(ratio_o));

  p_zero_frac_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && frac_i == '0 && mod_i != '0 && int_i != '0) |=> (ratio_o == {1'b0, $past(int_i)}));

  p_mod_zero_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mod_i == '0) |=> cfg_err_o);

  p_frac_clamp_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mod_i != '0 && frac_i >= mod_i) |=> cfg_err_o);

  p_int_clamp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && int_i == '0) |=> (cfg_err_o && ratio_o >= 1));
endmodule

bind frac_n_divider frac_n_divider_chk #(.INT_W(INT_W), .MOD_W(MOD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_i    (int_i),
  .frac_i   (frac_i),
  .mod_i    (mod_i),
  .pulse_o  (pulse_o),
  .ratio_o  (ratio_o),
  .cfg_err_o(cfg_err_o),
  .load     (load),
  .running  (running),
  .cnt      (cnt)
);

// File: tb/sim_frac_n_divider.sv
`timescale 1ns/1ps
module sim_frac_n_divider;
  localparam int INT_W = 12;
  localparam int MOD_W = 25;
  localparam int NV    = 8;

  // integer, fraction, modulus, expected error flag
  localparam int V_INT [NV] = '{10, 9, 7, 6, 5, 8, 0, 4};
  localparam int V_FRAC[NV] = '{ 0, 1, 2, 3, 0, 7, 1, 4};
  localparam int V_MOD [NV] = '{ 5, 5, 5, 7, 0, 4, 3, 4};
  localparam int V_ERR [NV] = '{ 0, 0, 0, 0, 1, 1, 1, 1};

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [INT_W-1:0]   int_i = '0;
  logic [MOD_W-1:0]   frac_i = '0;
  logic [MOD_W-1:0]   mod_i = '0;
  logic               pulse_o;
  logic [INT_W:0]     ratio_o;
  logic               cfg_err_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_acc = 0;

  always #2 clk = ~clk;

  frac_n_divider #(.INT_W(INT_W), .MOD_W(MOD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .int_i(int_i), .frac_i(frac_i), .mod_i(mod_i),
    .pulse_o(pulse_o), .ratio_o(ratio_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R4";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R8";
    endcase
  endfunction

  // reference length of the next cycle, from the requirement text
  function automatic int model_len(input int n, input int f, input int m);
    int mm, ff, nn, s;
    mm = (m == 0) ? 1 : m;
    ff = (f >= mm) ? mm - 1 : f;
    nn = (n == 0) ? 1 : n;
    if (m_acc >= mm) m_acc = 0;
    s = m_acc + ff;
    if (s >= mm) begin
      m_acc = s - mm;
      return nn + 1;
    end
    m_acc = s;
    return nn;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    m_acc = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // count sampled clocks up to and including the next pulse
  task automatic measure(output int len, output int rat);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!pulse_o && len < 10000);
    rat = int'(ratio_o);
  endtask

  task automatic run_cycles(input int n, input int f, input int m, input int ncyc,
                            input string req, output int total);
    int len, rat, exp;
    total = 0;
    for (int k = 0; k < ncyc; k++) begin
      exp = model_len(n, f, m);
      measure(len, rat);
      total += len;
      chk(len == exp, req, len, exp);
      chk(rat == exp, "R5", rat, exp);
    end
  endtask

  initial begin
    int len, rat, tot, c;
    // R1: reset state
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulse_o == 1'b0, "R1", pulse_o, 0);
    chk(ratio_o == '0, "R1", ratio_o, 0);
    chk(cfg_err_o == 1'b0, "R1", cfg_err_o, 0);

    for (int i = 0; i < NV; i++) begin
      int_i  = INT_W'(V_INT[i]);
      frac_i = MOD_W'(V_FRAC[i]);
      mod_i  = MOD_W'(V_MOD[i]);
      do_reset();
      run_cycles(V_INT[i], V_FRAC[i], V_MOD[i], 10, vec_req(i), tot);
      chk(cfg_err_o == V_ERR[i][0], vec_req(i), cfg_err_o, V_ERR[i]);
    end

    // R8: flag clears once legal words are sampled (vector 7 still applied)
    int_i = 12'd6; frac_i = 25'd0; mod_i = 25'd3;
    measure(len, rat);
    @(negedge clk);
    chk(cfg_err_o == 1'b0, "R8", cfg_err_o, 0);

    // R3: 900 + 1/5 over five cycles
    int_i = 12'd900; frac_i = 25'd1; mod_i = 25'd5;
    do_reset();
    run_cycles(900, 1, 5, 5, "R4", tot);
    chk(tot == 4501, "R3", tot, 4501);

    // R5: pulse lasts one clock
    measure(len, rat);
    @(negedge clk);
    chk(pulse_o == 1'b0, "R5", pulse_o, 0);

    // R6: mid-cycle change of the integer word
    int_i = 12'd20; frac_i = 25'd0; mod_i = 25'd5;
    do_reset();
    measure(len, rat);
    chk(len == 20, "R6", len, 20);
    c = 0;
    repeat (5) begin @(negedge clk); c++; end
    int_i = 12'd12;
    while (!pulse_o && c < 1000) begin @(negedge clk); c++; end
    chk(c == 20, "R6", c, 20);
    measure(len, rat);
    chk(len == 12, "R6", len, 12);
    chk(rat == 12, "R6", rat, 12);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule